// File: doc/BRIEF.md
# Strobed Control Register Bank

This block stands for the board logic that sits behind a shared 8-bit data bus. It holds three control registers: system, monitor routing and clock/routing. Each register has its own active-low select line. A register loads the bus value when its select rises while the shared active-low output enable is held low. The stored bits are decoded into registered control outputs: sample-rate code, sync source, external clock mode, word-clock scale, coax source, input routing, mute, phantom power, relay, input 1/2 mode, hi-Z select, codec power-down and the six monitor routes. A flag reports any field combination that has no defined meaning.

A host-side sequencer sits next to the bank and drives the bus pins. It carries out one register write at a time in a fixed order. After reset it writes the power-up settings by itself before it accepts any request. The bench normally loops the sequencer pins back into the bank's bus inputs, and it can drive the bus inputs directly to create illegal strobe patterns.

Top module: `ctl_strobe_regs`

## Requirements
- R1: A write runs in phases of STEP_CYCLES clocks each, in this order: data driven with enable high, then enable low, then only the chosen select low (held exactly STEP_CYCLES clocks, with the data and enable unchanged), then select high, then data 0xFF with enable high. Register index 0 selects the system register, 1 the monitor register and 2 the clock register, and these map to select bits 0, 1 and 2.
- R2: A register takes the bus value that was present while its select was low. The load happens on the low-to-high transition of that select, and only if the enable was low.
- R3: A select rise that happens while the enable is high leaves every register unchanged.
- R4: While more than one select is low, collide_err is high. It stays high until all selects are high again. A rise that ends such an overlap writes no register.
- R5: Reset leaves the system register at 0x08 (phantom off, codec powered down), and the other two registers at 0. busy is high until the sequencer has written 0x08 and then 0x88 to the system register, and 0 to the monitor and clock registers.
- R6: Clock register decode: bits 2:0 are rate_code (0 = 44.1 kHz through 5 = 192 kHz), bit 3 is ext_sync, bit 4 is wc_256x, bit 5 is coax_i2s, bit 6 is in12_from_a34 and bit 7 is in34_from_dig.
- R7: ext_mode is 0 for S/PDIF sync (bits 4,2:0 = 0000 with bit 3 set), 1 for 1x word clock (0010), and 2 for 256x word clock (1010). It is 3 when sync is internal or the pattern is not one of these.
- R8: System register decode: bit 0 is mic_relay, bit 1 is phantom_48v, bit 2 is hw_mute, bit 3 is phantom_off, bits 5:4 are in12_mode (00 line, 01 mic, 11 mic with low-cut), bit 6 is in34_hiz. codec_pdn is the inverse of bit 7.
- R9: mon_route equals bits 5:0 of the monitor register. Bits 0 to 3 route the inputs to the monitors, bit 4 routes output 3/4 to monitor 1/2, and bit 5 routes output 1/2 to monitor 3/4.
- R10: illegal is high when in12_mode is 10, when internal sync has a rate code of 6 or 7, or when external sync has ext_mode 3.
- R11: A request is taken only when busy is low and the register index is below 3. A request with index 3 starts no write and leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request |
| req_reg | input | 2 | Register index of the request |
| req_data | input | 8 | Value to write |
| busy | output | 1 | Sequencer is active or power-up writes are pending |
| host_data | output | 8 | Sequencer data pins |
| host_oe_n | output | 1 | Sequencer enable pin, active low |
| host_sel_n | output | 3 | Sequencer select pins, active low |
| bus_data | input | 8 | Bank data input |
| bus_oe_n | input | 1 | Bank enable input, active low |
| bus_sel_n | input | 3 | Bank select inputs, active low |
| rate_code | output | 3 | Internal rate code |
| ext_sync | output | 1 | External sync selected |
| ext_mode | output | 2 | External clock mode |
| wc_256x | output | 1 | Word clock at 256x |
| coax_i2s | output | 1 | Coax output carries I2S |
| in12_from_a34 | output | 1 | Input 1/2 taken from analog 3/4 |
| in34_from_dig | output | 1 | Input 3/4 taken from digital in |
| hw_mute | output | 1 | Hardware mute |
| phantom_48v | output | 1 | Phantom 48 V select |
| phantom_off | output | 1 | Phantom supply off |
| mic_relay | output | 1 | Mic relay on |
| in12_mode | output | 2 | Input 1/2 mode |
| in34_hiz | output | 1 | Input 3/4 hi-Z |
| codec_pdn | output | 1 | Codec in power-down |
| mon_route | output | 6 | Monitor routing switches |
| illegal | output | 1 | Undefined field combination stored |
| collide_err | output | 1 | Overlapping selects seen |

## Verification
The assertions assume that the bus inputs are synchronous to clk and change only once per cycle. On the host pins they assume the enable and data never move while a select is low. The stimulus drives every bus input at the falling edge. When the bench takes the bus away from the sequencer, it does so only while the sequencer is idle, and it always returns all selects high before handing the bus back.

// File: rtl/ctl_strobe_pkg.sv
package ctl_strobe_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned NUM_REGS = 3;
  localparam int unsigned IDX_W    = 2;
  localparam int unsigned INIT_N   = 4;

  localparam logic [IDX_W-1:0] IDX_SYS = 2'd0;
  localparam logic [IDX_W-1:0] IDX_MON = 2'd1;
  localparam logic [IDX_W-1:0] IDX_CLK = 2'd2;

  localparam logic [REG_W-1:0] RST_SYS = 8'h08;
  localparam logic [REG_W-1:0] RST_MON = 8'h00;
  localparam logic [REG_W-1:0] RST_CLK = 8'h00;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_DRIVE, SQ_ENABLE, SQ_STROBE, SQ_RISE, SQ_RELEASE
  } seq_state_e;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic [REG_W-1:0] val;
  } wr_item_t;

  function automatic wr_item_t power_up_item(input logic [2:0] n);
    wr_item_t it;
    case (n)
      3'd0:    begin it.idx = IDX_SYS; it.val = 8'h08; end
      3'd1:    begin it.idx = IDX_SYS; it.val = 8'h88; end
      3'd2:    begin it.idx = IDX_MON; it.val = 8'h00; end
      default: begin it.idx = IDX_CLK; it.val = 8'h00; end
    endcase
    return it;
  endfunction

  function automatic logic reset_value_bit(input int unsigned r, input int unsigned b);
    logic [REG_W-1:0] v;
    v = (r == 0) ? RST_SYS : (r == 1) ? RST_MON : RST_CLK;
    return v[b];
  endfunction

  function automatic logic several_low(input logic [NUM_REGS-1:0] s);
    int unsigned n;
    n = 0;
    for (int unsigned i = 0; i < NUM_REGS; i++) n += {31'd0, ~s[i]};
    return n > 1;
  endfunction
endpackage

// File: rtl/ctl_host_seq.sv
module ctl_host_seq
  import ctl_strobe_pkg::*;
#(
  parameter int unsigned STEP_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [IDX_W-1:0]    req_reg,
  input  logic [REG_W-1:0]    req_data,
  output logic                busy,
  output logic [REG_W-1:0]    host_data,
  output logic                host_oe_n,
  output logic [NUM_REGS-1:0] host_sel_n
);
  localparam int unsigned CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

  seq_state_e     state;
  logic [CW-1:0]  cnt;
  logic [2:0]     init_idx;
  logic           init_done;
  logic [IDX_W-1:0] cur_idx;
  wr_item_t       boot;

  assign boot = power_up_item(init_idx);
  assign busy = (state != SQ_IDLE) || !init_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      cnt        <= '0;
      init_idx   <= '0;
      init_done  <= 1'b0;
      cur_idx    <= '0;
      host_data  <= '1;
      host_oe_n  <= 1'b1;
      host_sel_n <= '1;
    end else begin
      case (state)
        SQ_IDLE: begin
          cnt <= '0;
          if (!init_done) begin
            if (init_idx == 3'(INIT_N)) begin
              init_done <= 1'b1;
            end else begin
              init_idx  <= init_idx + 3'd1;
              cur_idx   <= boot.idx;
              host_data <= boot.val;
              state     <= SQ_DRIVE;
            end
          end else if (req_valid && (req_reg < IDX_W'(NUM_REGS))) begin
            cur_idx   <= req_reg;
            host_data <= req_data;
            state     <= SQ_DRIVE;
          end
        end
        default: begin
          if (cnt == LAST) begin
            cnt <= '0;
            case (state)
              SQ_DRIVE: begin
                host_oe_n <= 1'b0;
                state     <= SQ_ENABLE;
              end
              SQ_ENABLE: begin
                for (int unsigned i = 0; i < NUM_REGS; i++)
                  host_sel_n[i] <= (cur_idx != IDX_W'(i));
                state <= SQ_STROBE;
              end
              SQ_STROBE: begin
                host_sel_n <= '1;
                state      <= SQ_RISE;
              end
              SQ_RISE: begin
                host_data <= '1;
                host_oe_n <= 1'b1;
                state     <= SQ_RELEASE;
              end
              default: state <= SQ_IDLE;
            endcase
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ctl_strobe_bank.sv
module ctl_strobe_bank
  import ctl_strobe_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [REG_W-1:0]    bus_data,
  input  logic                bus_oe_n,
  input  logic [NUM_REGS-1:0] bus_sel_n,
  output logic [REG_W-1:0]    sys_r,
  output logic [REG_W-1:0]    mon_r,
  output logic [REG_W-1:0]    clk_r,
  output logic                collide_err
);
  logic [REG_W-1:0]    d_q;
  logic                oe_q;
  logic [NUM_REGS-1:0] sel_q;
  logic                overlap_now;
  logic [REG_W-1:0]    regs [NUM_REGS];

  assign overlap_now = several_low(sel_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      d_q         <= '1;
      oe_q        <= 1'b1;
      sel_q       <= '1;
      collide_err <= 1'b0;
    end else begin
      d_q   <= bus_data;
      oe_q  <= bus_oe_n;
      sel_q <= bus_sel_n;
      if (&sel_q) collide_err <= 1'b0;
      else if (overlap_now) collide_err <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [REG_W-1:0] rst_val;
    logic             load;
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
      assign rst_val[b] = reset_value_bit(g, b);
    end
    assign load = !sel_q[g] && bus_sel_n[g] && !oe_q && !overlap_now && !collide_err;
    always_ff @(posedge clk) begin
      if (rst) regs[g] <= rst_val;
      else if (load) regs[g] <= d_q;
    end
  end

  assign sys_r = regs[IDX_SYS];
  assign mon_r = regs[IDX_MON];
  assign clk_r = regs[IDX_CLK];
endmodule

// File: rtl/ctl_field_decode.sv
module ctl_field_decode
  import ctl_strobe_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] sys_r,
  input  logic [REG_W-1:0] mon_r,
  input  logic [REG_W-1:0] clk_r,
  output logic [2:0]       rate_code,
  output logic             ext_sync,
  output logic [1:0]       ext_mode,
  output logic             wc_256x,
  output logic             coax_i2s,
  output logic             in12_from_a34,
  output logic             in34_from_dig,
  output logic             hw_mute,
  output logic             phantom_48v,
  output logic             phantom_off,
  output logic             mic_relay,
  output logic [1:0]       in12_mode,
  output logic             in34_hiz,
  output logic             codec_pdn,
  output logic [5:0]       mon_route,
  output logic             illegal
);
  logic [1:0] mode_n;
  logic       bad_n;

  always_comb begin
    case ({clk_r[4], clk_r[2:0]})
      4'b0000: mode_n = 2'd0;
      4'b0010: mode_n = 2'd1;
      4'b1010: mode_n = 2'd2;
      default: mode_n = 2'd3;
    endcase
    if (!clk_r[3]) mode_n = 2'd3;
    bad_n = (sys_r[5:4] == 2'b10)
          || (!clk_r[3] && (clk_r[2:0] > 3'd5))
          || (clk_r[3] && (mode_n == 2'd3));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_code     <= RST_CLK[2:0];
      ext_sync      <= 1'b0;
      ext_mode      <= 2'd3;
      wc_256x       <= 1'b0;
      coax_i2s      <= 1'b0;
      in12_from_a34 <= 1'b0;
      in34_from_dig <= 1'b0;
      hw_mute       <= RST_SYS[2];
      phantom_48v   <= RST_SYS[1];
      phantom_off   <= RST_SYS[3];
      mic_relay     <= RST_SYS[0];
      in12_mode     <= RST_SYS[5:4];
      in34_hiz      <= RST_SYS[6];
      codec_pdn     <= !RST_SYS[7];
      mon_route     <= RST_MON[5:0];
      illegal       <= 1'b0;
    end else begin
      rate_code     <= clk_r[2:0];
      ext_sync      <= clk_r[3];
      ext_mode      <= mode_n;
      wc_256x       <= clk_r[4];
      coax_i2s      <= clk_r[5];
      in12_from_a34 <= clk_r[6];
      in34_from_dig <= clk_r[7];
      hw_mute       <= sys_r[2];
      phantom_48v   <= sys_r[1];
      phantom_off   <= sys_r[3];
      mic_relay     <= sys_r[0];
      in12_mode     <= sys_r[5:4];
      in34_hiz      <= sys_r[6];
      codec_pdn     <= !sys_r[7];
      mon_route     <= mon_r[5:0];
      illegal       <= bad_n;
    end
  end
endmodule

// File: rtl/ctl_strobe_regs.sv
module ctl_strobe_regs
  import ctl_strobe_pkg::*;
#(
  parameter int unsigned STEP_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_reg,
  input  logic [7:0] req_data,
  output logic       busy,
  output logic [7:0] host_data,
  output logic       host_oe_n,
  output logic [2:0] host_sel_n,
  input  logic [7:0] bus_data,
  input  logic       bus_oe_n,
  input  logic [2:0] bus_sel_n,
  output logic [2:0] rate_code,
  output logic       ext_sync,
  output logic [1:0] ext_mode,
  output logic       wc_256x,
  output logic       coax_i2s,
  output logic       in12_from_a34,
  output logic       in34_from_dig,
  output logic       hw_mute,
  output logic       phantom_48v,
  output logic       phantom_off,
  output logic       mic_relay,
  output logic [1:0] in12_mode,
  output logic       in34_hiz,
  output logic       codec_pdn,
  output logic [5:0] mon_route,
  output logic       illegal,
  output logic       collide_err
);
  logic [REG_W-1:0] sys_r, mon_r, clk_r;

  ctl_host_seq #(.STEP_CYCLES(STEP_CYCLES)) u_seq (
    .clk, .rst, .req_valid, .req_reg, .req_data, .busy,
    .host_data, .host_oe_n, .host_sel_n
  );

  ctl_strobe_bank u_bank (
    .clk, .rst, .bus_data, .bus_oe_n, .bus_sel_n,
    .sys_r, .mon_r, .clk_r, .collide_err
  );

  ctl_field_decode u_dec (
    .clk, .rst, .sys_r, .mon_r, .clk_r,
    .rate_code, .ext_sync, .ext_mode, .wc_256x, .coax_i2s,
    .in12_from_a34, .in34_from_dig, .hw_mute, .phantom_48v, .phantom_off,
    .mic_relay, .in12_mode, .in34_hiz, .codec_pdn, .mon_route, .illegal
  );
endmodule

// File: rtl/ctl_strobe_regs_chk.sv
module ctl_strobe_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [1:0] req_reg,
  input logic       busy,
  input logic [7:0] host_data,
  input logic       host_oe_n,
  input logic [2:0] host_sel_n,
  input logic [2:0] bus_sel_n,
  input logic [1:0] ext_mode,
  input logic       ext_sync,
  input logic [1:0] in12_mode,
  input logic       illegal,
  input logic       collide_err
);
  // R1: a select is low only with the enable low
  a_r1_sel_needs_oe: assert property (@(posedge clk) disable iff (rst)
    (host_sel_n != 3'b111) |-> !host_oe_n);
  // R1: the sequencer never lowers two selects
  a_r1_single_sel: assert property (@(posedge clk) disable iff (rst)
    $countones(~host_sel_n) <= 1);
  // R1: data is held while a select is low
  a_r1_data_stable: assert property (@(posedge clk) disable iff (rst)
    (host_sel_n != 3'b111) |-> $stable(host_data));
  // R4: overlapping selects raise the collision flag two clocks later
  a_r4_collide_flag: assert property (@(posedge clk) disable iff (rst)
    ($countones(~bus_sel_n) > 1) |-> ##2 collide_err);
  // R10: reserved input mode is flagged
  a_r10_mode_illegal: assert property (@(posedge clk) disable iff (rst)
    (in12_mode == 2'b10) |-> illegal);
  // R7: an external mode code needs external sync
  a_r7_mode_needs_ext: assert property (@(posedge clk) disable iff (rst)
    (ext_mode != 2'd3) |-> ext_sync);
  // R11: a request for index 3 starts nothing
  a_r11_bad_index_idle: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_reg == 2'd3 && !busy) |=> !busy);
endmodule

bind ctl_strobe_regs ctl_strobe_regs_chk i_chk (
  .clk, .rst, .req_valid, .req_reg, .busy, .host_data, .host_oe_n,
  .host_sel_n, .bus_sel_n, .ext_mode, .ext_sync, .in12_mode, .illegal,
  .collide_err
);

// File: tb/test_ctl_strobe_regs.sv
module test_ctl_strobe_regs;
  localparam int CLK_PERIOD = 10;
  localparam int STEP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_reg = '0;
  logic [7:0] req_data = '0;
  logic busy;
  logic [7:0] host_data;
  logic host_oe_n;
  logic [2:0] host_sel_n;
  logic ovr = 1'b0;
  logic [7:0] tb_data = 8'hFF;
  logic tb_oe_n = 1'b1;
  logic [2:0] tb_sel_n = 3'b111;
  logic [7:0] bus_data;
  logic bus_oe_n;
  logic [2:0] bus_sel_n;
  logic [2:0] rate_code;
  logic ext_sync, wc_256x, coax_i2s, in12_from_a34, in34_from_dig;
  logic [1:0] ext_mode, in12_mode;
  logic hw_mute, phantom_48v, phantom_off, mic_relay, in34_hiz, codec_pdn;
  logic [5:0] mon_route;
  logic illegal, collide_err;

  assign bus_data  = ovr ? tb_data  : host_data;
  assign bus_oe_n  = ovr ? tb_oe_n  : host_oe_n;
  assign bus_sel_n = ovr ? tb_sel_n : host_sel_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_strobe_regs #(.STEP_CYCLES(STEP)) i_ctl_strobe_regs (
    .clk, .rst, .req_valid, .req_reg, .req_data, .busy, .host_data,
    .host_oe_n, .host_sel_n, .bus_data, .bus_oe_n, .bus_sel_n,
    .rate_code, .ext_sync, .ext_mode, .wc_256x, .coax_i2s,
    .in12_from_a34, .in34_from_dig, .hw_mute, .phantom_48v, .phantom_off,
    .mic_relay, .in12_mode, .in34_hiz, .codec_pdn, .mon_route, .illegal,
    .collide_err
  );

  typedef struct {
    logic [25:0] v;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_sys = 8'h08, m_mon = 8'h00, m_clk = 8'h00;

  function automatic logic [25:0] expect_vec(input logic [7:0] s, input logic [7:0] m,
                                             input logic [7:0] c, input logic col);
    logic [1:0] em;
    logic bad;
    case ({c[4], c[2:0]})
      4'b0000: em = 2'd0;
      4'b0010: em = 2'd1;
      4'b1010: em = 2'd2;
      default: em = 2'd3;
    endcase
    if (!c[3]) em = 2'd3;
    bad = (s[5:4] == 2'b10) || (!c[3] && c[2:0] > 3'd5) || (c[3] && em == 2'd3);
    return {c[2:0], c[3], c[4], c[5], c[6], c[7], em, s[2], s[1], s[3], s[0],
            s[5:4], s[6], !s[7], m[5:0], bad, col};
  endfunction

  function automatic logic [25:0] actual_vec();
    return {rate_code, ext_sync, wc_256x, coax_i2s, in12_from_a34, in34_from_dig,
            ext_mode, hw_mute, phantom_48v, phantom_off, mic_relay, in12_mode,
            in34_hiz, codec_pdn, mon_route, illegal, collide_err};
  endfunction

  // monitor: pops expected items and compares against the design
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [25:0] a;
        it = q.pop_front();
        a = actual_vec();
        n_chk++;
        if (a !== it.v) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, a, it.v);
        end
      end
    end
  end

  task automatic push_expect(input string tag, input logic col);
    item_t it;
    it.v = expect_vec(m_sys, m_mon, m_clk, col);
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic scalar_check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] idx, input logic [7:0] val, input string tag);
    int low_cyc = 0;
    int bad_ph = 0;
    @(negedge clk);
    req_valid = 1'b1; req_reg = idx; req_data = val;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy) begin
      if (idx < 2'd3 && host_sel_n[idx] == 1'b0) begin
        low_cyc++;
        if (host_oe_n !== 1'b0 || host_data !== val) bad_ph++;
      end
      @(negedge clk);
    end
    if (idx < 2'd3) begin
      // R1: strobe length, enable and data during strobe, idle pins after
      scalar_check("R1 strobe cycles", low_cyc, STEP);
      scalar_check("R1 phase content", bad_ph, 0);
      scalar_check("R1 release pins", {host_data, host_oe_n, host_sel_n}, {8'hFF, 1'b1, 3'b111});
      if (idx == 2'd0) m_sys = val;
      else if (idx == 2'd1) m_mon = val;
      else m_clk = val;
    end
    repeat (3) @(negedge clk);
    push_expect(tag, 1'b0);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_bad++;
    $display("FAIL R5 watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R5: power-down state before the power-up writes land
    push_expect("R5 reset values", 1'b0);
    scalar_check("R5 busy during init", busy, 1);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    m_sys = 8'h88;
    push_expect("R5 after init", 1'b0);

    // R6 rates, R7 modes
    write_reg(2'd2, 8'h05, "R6 rate 192k");
    write_reg(2'd2, 8'hE3, "R6 rate 96k and routing bits");
    write_reg(2'd2, 8'h08, "R7 spdif sync");
    write_reg(2'd2, 8'h0A, "R7 word clock 1x");
    write_reg(2'd2, 8'h1A, "R7 word clock 256x");
    write_reg(2'd2, 8'h09, "R10 bad external pattern");
    write_reg(2'd2, 8'h06, "R10 reserved rate code");
    write_reg(2'd2, 8'h14, "R6 rate 176.4k with wc bit");
    // R8 system fields
    write_reg(2'd0, 8'hB7, "R8 mic low-cut phantom 48v");
    write_reg(2'd0, 8'h6C, "R8 hi-z codec down mute");
    write_reg(2'd0, 8'hA0, "R10 reserved input mode");
    write_reg(2'd0, 8'h91, "R8 mic mode");
    // R9 monitor
    write_reg(2'd1, 8'h2A, "R9 monitor pattern a");
    write_reg(2'd1, 8'hD5, "R9 monitor pattern b");
    // R11: index 3 does nothing
    @(negedge clk);
    req_valid = 1'b1; req_reg = 2'd3; req_data = 8'h55;
    @(negedge clk);
    req_valid = 1'b0;
    scalar_check("R11 no busy for index 3", busy, 0);
    push_expect("R11 outputs unchanged", 1'b0);

    // R3: select rise with enable high
    ovr = 1'b1;
    tb_data = 8'h55; tb_oe_n = 1'b1; tb_sel_n = 3'b011;
    repeat (3) @(negedge clk);
    tb_sel_n = 3'b111;
    repeat (4) @(negedge clk);
    push_expect("R3 enable high ignored", 1'b0);

    // R2: direct strobe on the bus loads the clock register
    tb_data = 8'hC1; tb_oe_n = 1'b0; tb_sel_n = 3'b011;
    repeat (3) @(negedge clk);
    tb_sel_n = 3'b111;
    @(negedge clk);
    tb_data = 8'hFF; tb_oe_n = 1'b1;
    repeat (3) @(negedge clk);
    m_clk = 8'hC1;
    push_expect("R2 direct strobe load", 1'b0);

    // R4: two selects low at once
    tb_data = 8'h3C; tb_oe_n = 1'b0; tb_sel_n = 3'b100;
    repeat (4) @(negedge clk);
    push_expect("R4 collide flag high", 1'b1);
    tb_sel_n = 3'b110;
    repeat (3) @(negedge clk);
    scalar_check("R4 flag held until all high", collide_err, 1);
    tb_sel_n = 3'b111;
    repeat (4) @(negedge clk);
    tb_oe_n = 1'b1; tb_data = 8'hFF;
    push_expect("R4 write blocked", 1'b0);
    ovr = 1'b0;

    write_reg(2'd0, 8'h88, "R2 write after collision");
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule